// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits behind a receive MAC and looks at the destination address that opens every incoming frame. The address octets arrive one per cycle on a byte stream, with a start strobe on the first octet. Once the last octet has been taken, the filter gives a one-cycle decision: accept or drop. It also gives a three-bit code that names the rule that let the frame through.

Five rules are available:
- a promiscuous switch that passes everything;
- a programmed station address that must match exactly;
- recognition of the all-ones broadcast address, which can be turned off;
- two 64-entry hash tables, one for unicast and one for multicast destinations.

The hash index is taken from a CRC-32 that runs over the address octets as they stream in, so no extra cycles are spent after the last octet. The station address, both tables and the two control bits are loaded through a simple write-only register port.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: After a synchronous active-low reset, every configuration register is zero and the outputs `dec_valid`, `dec_accept` and `dec_reason` are zero. Register writes use `cfg_addr` as follows:
  - 0: station address bits 31:0
  - 1: station address bits 47:32, taken from `cfg_wdata[15:0]`
  - 2 and 3: unicast table bits 31:0 and 63:32
  - 4 and 5: multicast table bits 31:0 and 63:32
  - 6: control, where bit 0 is promiscuous and bit 1 is broadcast-reject
- R2: A frame begins with a byte that has both `rx_vld` and `rx_sof` high. The next five bytes with `rx_vld` high complete the address, and idle cycles between bytes are allowed. The first byte is the most significant octet, address bits 47:40. `dec_valid` is high for exactly one cycle, and that cycle is the one that follows the clock edge on which the sixth byte is taken.
- R3: Bytes that arrive after the sixth, and bytes without `rx_sof` when no frame is open, produce no decision. A new `rx_sof` in the middle of an address drops the partial address and starts again.
- R4: When promiscuous is set, every frame is accepted with reason 5. This rule comes before all others.
- R5: When promiscuous is clear and the address equals the station address, the frame is accepted with reason 1. This holds even when the address is broadcast or multicast.
- R6: The all-ones address, when it is not an exact match, is accepted with reason 2 if broadcast-reject is clear. If broadcast-reject is set, it is rejected with reason 0, and neither hash table is consulted.
- R7: The hash index is bits 31:26 of a 32-bit register. The register is seeded with all ones. For each octet in arrival order, and for each bit of that octet starting at the least significant, the register is shifted right once, and XORed with 0xEDB88320 when the bit that left the register differs from the data bit. No final inversion is applied.
- R8: Any other address whose group bit (bit 40, the least significant bit of the first octet) is 0 is accepted with reason 3 when the unicast table bit at the hash index is set. Otherwise it is rejected.
- R9: Any other address whose group bit is 1 is accepted with reason 4 when the multicast table bit at the hash index is set. Otherwise it is rejected.
- R10: A rejected frame reports `dec_accept`=0 with reason 0. While `dec_valid` is low, `dec_accept` and `dec_reason` are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_sof | input | 1 | Marks the first address octet |
| rx_vld | input | 1 | An octet is present on `rx_byte` |
| rx_byte | input | 8 | Address octet |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| dec_valid | output | 1 | Decision strobe, one cycle |
| dec_accept | output | 1 | Frame accepted |
| dec_reason | output | 3 | 0 none, 1 exact, 2 broadcast, 3 unicast hash, 4 multicast hash, 5 promiscuous |

## Verification
The bench builds the block with its defaults: a six-octet address, a six-bit hash index into 64-entry tables, and 32-bit register words. At this size, sweeping all 256 values of the last octet for both a unicast and a multicast prefix sends frames to indices spread across both tables. Flipping each of the 48 station-address bits one at a time probes the exact comparator at every bit position. Broadcast-reject, promiscuous mode and the priority cases run on the same small setup, as do the framing cases: gaps between bytes, extra bytes, stray bytes and a restart.

// File: rtl/eth_rxaf_pkg.sv
// Package: shared reason codes and the per-octet CRC step used for hashing.
// Assumes octets are folded in least significant bit first.
package eth_rxaf_pkg;

    typedef enum logic [2:0] {
        RSN_NONE    = 3'd0,
        RSN_EXACT   = 3'd1,
        RSN_BCAST   = 3'd2,
        RSN_IHASH   = 3'd3,
        RSN_GHASH   = 3'd4,
        RSN_PROMISC = 3'd5
    } rsn_e;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;

    // Fold one octet into a reflected CRC-32 register.
    function automatic logic [31:0] crc_octet(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int b = 0; b < 8; b++) begin
            if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY_REFL;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/daf_cfg_regs.sv
// Module: configuration store for the address filter.
// Holds the station address, both hash tables and two control bits.
// Assumes the table is exactly two register words wide and the address
// is wider than one word but no wider than two.
module daf_cfg_regs #(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_W     = 6,
    parameter int REG_W      = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [2:0]                 cfg_addr,
    input  logic [REG_W-1:0]           cfg_wdata,
    output logic [8*ADDR_BYTES-1:0]    station_o,
    output logic [(1<<HASH_W)-1:0]     ihash_o,
    output logic [(1<<HASH_W)-1:0]     ghash_o,
    output logic                       promisc_o,
    output logic                       bcrej_o
);
    localparam int AW = 8 * ADDR_BYTES;
    localparam int TW = 1 << HASH_W;

    logic unused_hi_bits;
    assign unused_hi_bits = ^cfg_wdata[REG_W-1:AW-REG_W];

    // Register writes, one word per access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            station_o <= '0;
            ihash_o   <= '0;
            ghash_o   <= '0;
            promisc_o <= 1'b0;
            bcrej_o   <= 1'b0;
        end else if (cfg_we) begin
            case (cfg_addr)
                3'd0: station_o[REG_W-1:0]  <= cfg_wdata;
                3'd1: station_o[AW-1:REG_W] <= cfg_wdata[AW-REG_W-1:0];
                3'd2: ihash_o[REG_W-1:0]    <= cfg_wdata;
                3'd3: ihash_o[TW-1:REG_W]   <= cfg_wdata[TW-REG_W-1:0];
                3'd4: ghash_o[REG_W-1:0]    <= cfg_wdata;
                3'd5: ghash_o[TW-1:REG_W]   <= cfg_wdata[TW-REG_W-1:0];
                3'd6: begin
                    promisc_o <= cfg_wdata[0];
                    bcrej_o   <= cfg_wdata[1];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/daf_addr_capture.sv
// Module: assembles the destination address from the octet stream and
// computes the CRC hash index alongside it. It flags the cycle in which
// the final octet is present, and in that cycle it offers the complete
// address and index without a register in between.
// Assumes ADDR_BYTES >= 2.
module daf_addr_capture
    import eth_rxaf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_W     = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_sof,
    input  logic                    rx_vld,
    input  logic [7:0]              rx_byte,
    output logic                    last_o,
    output logic [8*ADDR_BYTES-1:0] addr_o,
    output logic [HASH_W-1:0]       idx_o
);
    localparam int AW    = 8 * ADDR_BYTES;
    localparam int CNT_W = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ADDR_BYTES - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(ADDR_BYTES);

    logic [CNT_W-1:0] cnt_q;
    logic [AW-1:0]    addr_q;
    logic [31:0]      crc_q;
    logic             take_first, take_more, in_frame;
    logic [31:0]      crc_nxt;
    logic [AW-1:0]    addr_nxt;

    // Decide which octets belong to the address, then form the next shift and CRC values.
    always_comb begin
        in_frame   = (cnt_q != '0) && (cnt_q < FULL_CNT);
        take_first = rx_vld && rx_sof;
        take_more  = rx_vld && !rx_sof && in_frame;
        crc_nxt    = crc_octet(take_first ? CRC_SEED : crc_q, rx_byte);
        addr_nxt   = take_first ? {{(AW-8){1'b0}}, rx_byte} : {addr_q[AW-9:0], rx_byte};
        last_o     = take_more && (cnt_q == LAST_CNT);
        addr_o     = addr_nxt;
        idx_o      = crc_nxt[31 -: HASH_W];
    end

    // Octet counter, address shift register and running CRC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            addr_q <= '0;
            crc_q  <= CRC_SEED;
        end else if (take_first || take_more) begin
            cnt_q  <= take_first ? CNT_W'(1) : cnt_q + CNT_W'(1);
            addr_q <= addr_nxt;
            crc_q  <= crc_nxt;
        end
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);

    // R3
    last_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> (cnt_q != '0) && !rx_sof);
endmodule

// File: rtl/daf_decide.sv
// Module: applies the acceptance rules in priority order and registers the
// result. The order is promiscuous, exact station match, broadcast, then
// the hash table that the group bit selects. Assumes its inputs are valid
// in the cycle where last_i is high.
module daf_decide
    import eth_rxaf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_W     = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       last_i,
    input  logic [8*ADDR_BYTES-1:0]    addr_i,
    input  logic [HASH_W-1:0]          idx_i,
    input  logic [8*ADDR_BYTES-1:0]    station_i,
    input  logic [(1<<HASH_W)-1:0]     ihash_i,
    input  logic [(1<<HASH_W)-1:0]     ghash_i,
    input  logic                       promisc_i,
    input  logic                       bcrej_i,
    output logic                       dec_valid_o,
    output logic                       dec_accept_o,
    output rsn_e                       dec_reason_o
);
    localparam int AW = 8 * ADDR_BYTES;

    rsn_e rsn_d;
    logic is_bcast, group_bit;

    // Rule evaluation in priority order.
    always_comb begin
        is_bcast  = &addr_i;
        group_bit = addr_i[AW-8];
        if (promisc_i)                rsn_d = RSN_PROMISC;
        else if (addr_i == station_i) rsn_d = RSN_EXACT;
        else if (is_bcast)            rsn_d = bcrej_i ? RSN_NONE : RSN_BCAST;
        else if (group_bit)           rsn_d = ghash_i[idx_i] ? RSN_GHASH : RSN_NONE;
        else                          rsn_d = ihash_i[idx_i] ? RSN_IHASH : RSN_NONE;
    end

    // Decision register; the outputs stay at zero except in the strobe cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid_o  <= 1'b0;
            dec_accept_o <= 1'b0;
            dec_reason_o <= RSN_NONE;
        end else begin
            dec_valid_o  <= last_i;
            dec_accept_o <= last_i && (rsn_d != RSN_NONE);
            dec_reason_o <= last_i ? rsn_d : RSN_NONE;
        end
    end

    // R2
    valid_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_o |-> $past(last_i));

    // R4
    promisc_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_i && promisc_i |=> dec_accept_o && dec_reason_o == RSN_PROMISC);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_o |-> !dec_accept_o && dec_reason_o == RSN_NONE);

    // R10
    accept_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_o |-> dec_accept_o == (dec_reason_o != RSN_NONE));
endmodule

// File: rtl/eth_rx_addr_filter.sv
// Module: top of the receive destination address filter. It ties the
// configuration store, the address capture and the decision stage together.
// Assumes the default sizes: a six-octet address, a 64-entry table and
// 32-bit register words.
module eth_rx_addr_filter
    import eth_rxaf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_W     = 6,
    parameter int REG_W      = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_sof,
    input  logic             rx_vld,
    input  logic [7:0]       rx_byte,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic             dec_valid,
    output logic             dec_accept,
    output logic [2:0]       dec_reason
);
    localparam int AW = 8 * ADDR_BYTES;
    localparam int TW = 1 << HASH_W;

    logic [AW-1:0]     station, cap_addr;
    logic [TW-1:0]     ihash, ghash;
    logic              promisc, bcrej, cap_last;
    logic [HASH_W-1:0] cap_idx;
    rsn_e              reason;

    daf_cfg_regs #(.ADDR_BYTES(ADDR_BYTES), .HASH_W(HASH_W), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .station_o(station), .ihash_o(ihash),
        .ghash_o(ghash), .promisc_o(promisc), .bcrej_o(bcrej)
    );

    daf_addr_capture #(.ADDR_BYTES(ADDR_BYTES), .HASH_W(HASH_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_vld(rx_vld),
        .rx_byte(rx_byte), .last_o(cap_last), .addr_o(cap_addr), .idx_o(cap_idx)
    );

    daf_decide #(.ADDR_BYTES(ADDR_BYTES), .HASH_W(HASH_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .last_i(cap_last), .addr_i(cap_addr),
        .idx_i(cap_idx), .station_i(station), .ihash_i(ihash), .ghash_i(ghash),
        .promisc_i(promisc), .bcrej_i(bcrej), .dec_valid_o(dec_valid),
        .dec_accept_o(dec_accept), .dec_reason_o(reason)
    );

    assign dec_reason = reason;

    // R2
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);
endmodule

// File: tb/eth_rx_addr_filter_tb.sv
module eth_rx_addr_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_sof = 1'b0, rx_vld = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        dec_valid, dec_accept;
    logic [2:0]  dec_reason;

    int checks = 0;
    int errors = 0;

    // Bench-side copy of the configuration that was written.
    logic [47:0] st = '0;
    logic [63:0] ih = '0, gh = '0;
    logic        pr = 1'b0, br = 1'b0;

    always #10 clk = ~clk;

    eth_rx_addr_filter u_dut (
        .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_vld(rx_vld),
        .rx_byte(rx_byte), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .dec_valid(dec_valid),
        .dec_accept(dec_accept), .dec_reason(dec_reason)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Hash index as defined in R7.
    function automatic logic [5:0] hidx(input logic [47:0] a);
        logic [31:0] c;
        c = 32'hFFFFFFFF;
        for (int o = 0; o < 6; o++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = c[0] ^ a[47 - 8*o - 7 + b];
                c  = {1'b0, c[31:1]};
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return c[31:26];
    endfunction

    // Expected {accept, reason} per R4..R10.
    function automatic logic [3:0] model(input logic [47:0] a);
        if (pr)         return {1'b1, 3'd5};
        if (a == st)    return {1'b1, 3'd1};
        if (&a)         return br ? 4'd0 : {1'b1, 3'd2};
        if (a[40])      return gh[hidx(a)] ? {1'b1, 3'd4} : 4'd0;
        return ih[hidx(a)] ? {1'b1, 3'd3} : 4'd0;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_station(input logic [47:0] s);
        wr(3'd0, s[31:0]); wr(3'd1, {16'h0, s[47:32]}); st = s;
    endtask

    task automatic set_tables(input logic [63:0] i, input logic [63:0] g);
        wr(3'd2, i[31:0]); wr(3'd3, i[63:32]);
        wr(3'd4, g[31:0]); wr(3'd5, g[63:32]);
        ih = i; gh = g;
    endtask

    task automatic set_ctrl(input logic p, input logic b);
        wr(3'd6, {30'h0, b, p}); pr = p; br = b;
    endtask

    // Send one address with 'gap' idle cycles between octets, then check the decision.
    task automatic send(input logic [47:0] a, input int gap, input string tag);
        logic early;
        logic [3:0] exp;
        early = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (dec_valid) early = 1'b1;
            rx_vld = 1'b1; rx_sof = (i == 0); rx_byte = a[47 - 8*i -: 8];
            if (i < 5) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    if (dec_valid) early = 1'b1;
                    rx_vld = 1'b0; rx_sof = 1'b0;
                end
            end
        end
        @(negedge clk);
        rx_vld = 1'b0; rx_sof = 1'b0;
        exp = model(a);
        chk(tag, {28'h0, dec_valid, dec_accept, dec_reason}, {28'h0, 1'b1, exp});
        chk("R2 no early strobe", {31'h0, early}, 32'h0);
        @(negedge clk);
        chk("R2 single-cycle strobe", {31'h0, dec_valid}, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset outputs", {29'h0, dec_valid, dec_accept, dec_reason}, 32'h0);
        // R1 zero config: all-zero address matches zero station
        send(48'h0, 0, "R1 reset station");
        send(48'h0211_2233_4455, 0, "R10 empty tables reject");

        set_station(48'h0211_2233_4455);
        send(48'h0211_2233_4455, 0, "R5 exact");
        send(48'h0211_2233_4455, 3, "R2 gapped exact");
        set_tables(64'hA5A5_0F0F_3C3C_9966, 64'h5A69_F00F_C3C3_1248);
        for (int b = 0; b < 48; b++) send(st ^ (48'h1 << b), 0, "R5 bit flip");

        for (int x = 0; x < 256; x++) send({40'h02AA_BBCC_DD, 8'(x)}, 0, "R8 unicast sweep");
        for (int x = 0; x < 256; x++) send({40'h0100_5E00_01, 8'(x)}, 0, "R9 multicast sweep");
        for (int x = 0; x < 16; x++) send({8'(x), 40'h77_6655_4433}, 1, "R7 first octet sweep");

        // R6 broadcast on and off
        send(48'hFFFF_FFFF_FFFF, 0, "R6 broadcast accept");
        set_tables(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        set_ctrl(1'b0, 1'b1);
        send(48'hFFFF_FFFF_FFFF, 0, "R6 broadcast rejected");
        send(48'h0100_5E7F_0001, 0, "R9 full group table");
        send(48'h0A00_0000_0001, 0, "R8 full unicast table");

        // R4 promiscuous overrides everything
        set_tables(64'h0, 64'h0);
        set_ctrl(1'b1, 1'b1);
        send(48'hFFFF_FFFF_FFFF, 0, "R4 promisc broadcast");
        send(st, 0, "R4 promisc over exact");
        for (int x = 0; x < 16; x++) send({8'(x * 17), 40'h12_3456_789A}, 0, "R4 promisc sweep");

        // R5 exact takes priority over broadcast and group hash
        set_ctrl(1'b0, 1'b1);
        set_station(48'hFFFF_FFFF_FFFF);
        send(48'hFFFF_FFFF_FFFF, 0, "R5 exact over broadcast reject");
        set_tables(64'h0, 64'hFFFF_FFFF_FFFF_FFFF);
        set_station(48'h0300_0000_0042);
        send(48'h0300_0000_0042, 0, "R5 exact over group hash");
        set_ctrl(1'b0, 1'b0);

        // R3 extra octets after a complete address
        send(st, 0, "R3 before extras");
        seen = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (dec_valid) seen = 1'b1;
            rx_vld = 1'b1; rx_sof = 1'b0; rx_byte = 8'(i);
        end
        @(negedge clk); if (dec_valid) seen = 1'b1; rx_vld = 1'b0;
        @(negedge clk); if (dec_valid) seen = 1'b1;
        chk("R3 extra octets ignored", {31'h0, seen}, 32'h0);

        // R3 restart mid-address: partial frame then a full station address
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            rx_vld = 1'b1; rx_sof = (i == 0); rx_byte = 8'hF0 + 8'(i);
        end
        send(st, 0, "R3 restart");
        send(48'hFFFF_FFFF_FFFF, 2, "R6 gapped broadcast");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule